// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block is the command and protection logic behind a one-byte control register that sits on a two-wire serial bus as a slave. It does no bit-level shifting. A bus front end hands it decoded events as single-cycle strobes: start (or repeated start), a received device byte, a received address byte, a received data byte, and stop. For every received byte the block decides whether it is acknowledged. It keeps two volatile enable latches, a write-enable latch and a register-write-enable latch. It keeps a two-bit watchdog period field that models nonvolatile storage, and it returns the register image on reads.

The watchdog field can only change after a three-step unlock, with one complete write transaction per step. The first write sets the write-enable latch. The second sets the register-write-enable latch. The third carries the new field, which is stored when the stop arrives. Storing starts a busy period that stands in for the nonvolatile write time. During that period the block ignores the bus. A write-protect input, a supervisor reset input and several malformed transaction shapes all cancel or refuse the update.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset the watchdog field is 11, both latches are 0, nvBusy is 0, and a read returns 60h.
- R2: A device byte is acknowledged only when its upper seven bits equal 1011000. Bit 0 selects read (1) or write (0). If the device byte is not matched, the rest of the transaction is ignored.
- R3: An address byte is acknowledged only when it equals FFh. A read is acknowledged only after an accepted address in the same transaction (dummy write, then repeated start). The read returns {0, WD1, WD0, 0, 0, RWE, WE, 0} one cycle after the device byte.
- R4: A data byte with any of bits 7, 4, 3 or 0 set is not acknowledged. While the write-enable latch is 0, only a byte with bit 1 set and bit 2 clear is acknowledged. A refused byte changes nothing.
- R5: With the register-write-enable latch clear, an acknowledged byte followed by stop sets the write-enable latch to bit 1 and the register-write-enable latch to bit 1 AND bit 2. No busy period follows.
- R6: With both latches set, a byte with bit 1 set and bit 2 clear stores bits 6:5 as the watchdog field at stop and clears the register-write-enable latch. nvBusy is then high for NV_CYCLES cycles.
- R7: With both latches set, a byte with bit 2 set leaves the watchdog field unchanged and keeps the register-write-enable latch set.
- R8: While wp is high a data byte is not acknowledged, the watchdog field and write-enable latch do not change, and the register-write-enable latch is cleared.
- R9: A second data byte in one transaction is not acknowledged and cancels the whole write. A stop that comes before any data byte changes nothing.
- R10: While nvBusy is high, no byte is acknowledged and no event has any effect.
- R11: supReset drops any transaction in progress, including a pending write, and clears both latches.
- R12: A read transaction between unlock steps leaves both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startEv | input | 1 | Start or repeated start strobe |
| devEv | input | 1 | Device byte received strobe |
| devByte | input | 8 | Received device byte |
| addrEv | input | 1 | Address byte received strobe |
| addrByte | input | 8 | Received address byte |
| dataEv | input | 1 | Data byte received strobe |
| dataByte | input | 8 | Received data byte |
| stopEv | input | 1 | Stop strobe |
| wp | input | 1 | Write protect |
| supReset | input | 1 | Supervisor reset active |
| ackHit | output | 1 | Pulses one cycle after an acknowledged byte |
| rdValid | output | 1 | Pulses with rdData for an accepted read |
| rdData | output | 8 | Register image returned by a read |
| wdSel | output | 2 | Stored watchdog period field |
| nvBusy | output | 1 | Nonvolatile store in progress |

## Verification
The bench walks the unlock sequence one step at a time and reads the register back between steps.

- The escape byte with bit 2 set must leave the watchdog field alone. A design that decodes only bit 1 would store the field.
- A write-protected attempt must clear the register-write-enable latch. A design that only refuses the byte would leave the latch set.
- A second data byte must cancel the write. A design that keeps the last byte would commit it at stop.
- A supervisor reset between the data byte and the stop must drop the pending commit.
- Events sent during the busy period must get no acknowledge.
- The 02h, 06h, 02h order must clear the field. This catches a commit path that ignores zero field values.

// File: rtl/cfg_lock_pkg.sv
`timescale 1ns/1ps
package cfg_lock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_DEV, ST_WAIT_ADDR, ST_WAIT_DATA, ST_PEND, ST_ABORT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchData;   // capture accepted data fields
    logic applyStop;   // apply captured byte at stop
    logic clrRwe;      // protected attempt clears register-write-enable
    logic clrLatches;  // supervisor reset clears both latches
    logic loadRead;    // capture register image for read
  } ctlStrobe_t;

  localparam logic [7:0] RESERVED_MASK = 8'h99;
endpackage

// File: rtl/cfg_lock_ctrl.sv
`timescale 1ns/1ps
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter logic [6:0] DEV_ID   = 7'b1011000,
  parameter logic [7:0] REG_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       devEv,
  input  logic [7:0] devByte,
  input  logic       addrEv,
  input  logic [7:0] addrByte,
  input  logic       dataEv,
  input  logic [7:0] dataByte,
  input  logic       stopEv,
  input  logic       wp,
  input  logic       supReset,
  input  logic       weLatch,
  input  logic       nvBusy,
  output ctlStrobe_t strobe,
  output logic       ackHit,
  output logic       rdValid
);
  seqState_t state, nState;
  logic addrSet, nAddrSet, ackNext, rdNext;
  logic devMatch, addrMatch, resOk, enableByte;

  assign devMatch   = (devByte[7:1] == DEV_ID);
  assign addrMatch  = (addrByte == REG_ADDR);
  assign resOk      = ((dataByte & RESERVED_MASK) == 8'h00);
  assign enableByte = dataByte[1] && !dataByte[2];

  always_comb begin
    nState   = state;
    nAddrSet = addrSet;
    strobe   = '0;
    ackNext  = 1'b0;
    rdNext   = 1'b0;
    if (supReset) begin
      nState = ST_IDLE;
      nAddrSet = 1'b0;
      strobe.clrLatches = 1'b1;
    end else if (nvBusy) begin
      nState = ST_IDLE;
      nAddrSet = 1'b0;
    end else if (stopEv) begin
      strobe.applyStop = (state == ST_PEND);
      nState = ST_IDLE;
      nAddrSet = 1'b0;
    end else if (startEv) begin
      nState = ST_WAIT_DEV;
    end else begin
      case (state)
        ST_WAIT_DEV: if (devEv) begin
          nState = ST_IDLE;
          if (devMatch && !devByte[0]) begin
            ackNext = 1'b1;
            nState  = ST_WAIT_ADDR;
          end else if (devMatch && addrSet) begin
            ackNext = 1'b1;
            rdNext  = 1'b1;
            strobe.loadRead = 1'b1;
            nAddrSet = 1'b0;
          end
        end
        ST_WAIT_ADDR: if (addrEv) begin
          if (addrMatch) begin
            ackNext  = 1'b1;
            nAddrSet = 1'b1;
            nState   = ST_WAIT_DATA;
          end else begin
            nState = ST_IDLE;
          end
        end
        ST_WAIT_DATA: if (dataEv) begin
          nState = ST_ABORT;
          if (wp) begin
            strobe.clrRwe = 1'b1;
          end else if (resOk && (weLatch || enableByte)) begin
            ackNext = 1'b1;
            strobe.latchData = 1'b1;
            nState = ST_PEND;
          end
        end
        ST_PEND: if (dataEv) nState = ST_ABORT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrSet <= 1'b0;
      ackHit  <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      state   <= nState;
      addrSet <= nAddrSet;
      ackHit  <= ackNext;
      rdValid <= rdNext;
    end
  end
endmodule

// File: rtl/cfg_lock_dp.sv
`timescale 1ns/1ps
module cfg_lock_dp
  import cfg_lock_pkg::*;
#(
  parameter int NV_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [3:0] dataFields,  // {bit6, bit5, bit2, bit1}
  output logic       weLatch,
  output logic       nvBusy,
  output logic [1:0] wdSel,
  output logic [7:0] rdData
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(NV_CYCLES);

  logic [3:0]    pend;
  logic          rweLatch;
  logic [CW-1:0] busyCnt;

  assign nvBusy = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      weLatch  <= 1'b0;
      rweLatch <= 1'b0;
      wdSel    <= 2'b11;
      busyCnt  <= '0;
      rdData   <= '0;
    end else begin
      if (nvBusy) busyCnt <= busyCnt - 1'b1;
      if (strobe.latchData) pend <= dataFields;
      if (strobe.loadRead)
        rdData <= {1'b0, wdSel, 2'b00, rweLatch, weLatch, 1'b0};
      if (strobe.clrLatches) begin
        weLatch  <= 1'b0;
        rweLatch <= 1'b0;
      end else if (strobe.clrRwe) begin
        rweLatch <= 1'b0;
      end else if (strobe.applyStop) begin
        if (weLatch && rweLatch) begin
          if (pend[1]) begin
            weLatch <= pend[0];
          end else if (pend[0]) begin
            wdSel    <= pend[3:2];
            rweLatch <= 1'b0;
            busyCnt  <= BUSY_LOAD;
          end else begin
            weLatch  <= 1'b0;
            rweLatch <= 1'b0;
          end
        end else begin
          weLatch  <= pend[0];
          rweLatch <= pend[0] & pend[1];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_lock_seq.sv
`timescale 1ns/1ps
module cfg_lock_seq
  import cfg_lock_pkg::*;
#(
  parameter logic [6:0] DEV_ID    = 7'b1011000,
  parameter logic [7:0] REG_ADDR  = 8'hFF,
  parameter int         NV_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       devEv,
  input  logic [7:0] devByte,
  input  logic       addrEv,
  input  logic [7:0] addrByte,
  input  logic       dataEv,
  input  logic [7:0] dataByte,
  input  logic       stopEv,
  input  logic       wp,
  input  logic       supReset,
  output logic       ackHit,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic [1:0] wdSel,
  output logic       nvBusy
);
  ctlStrobe_t strobe;
  logic weLatch;

  cfg_lock_ctrl #(.DEV_ID(DEV_ID), .REG_ADDR(REG_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .startEv(startEv), .devEv(devEv), .devByte(devByte),
    .addrEv(addrEv), .addrByte(addrByte), .dataEv(dataEv), .dataByte(dataByte),
    .stopEv(stopEv), .wp(wp), .supReset(supReset), .weLatch(weLatch),
    .nvBusy(nvBusy), .strobe(strobe), .ackHit(ackHit), .rdValid(rdValid)
  );

  cfg_lock_dp #(.NV_CYCLES(NV_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dataFields({dataByte[6:5], dataByte[2:1]}),
    .weLatch(weLatch), .nvBusy(nvBusy), .wdSel(wdSel), .rdData(rdData)
  );
endmodule

// File: rtl/cfg_lock_chk.sv
`timescale 1ns/1ps
module cfg_lock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       devEv,
  input logic       addrEv,
  input logic       dataEv,
  input logic       wp,
  input logic       supReset,
  input logic       ackHit,
  input logic       rdValid,
  input logic [7:0] rdData,
  input logic [1:0] wdSel,
  input logic       nvBusy
);
  // R2
  ack_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackHit |-> $past(devEv || addrEv || dataEv));

  // R3
  read_layout_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[7] == 1'b0 && rdData[4:3] == 2'b00 && rdData[0] == 1'b0 && ackHit));

  // R6
  wd_change_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdSel != $past(wdSel)) |-> nvBusy);

  // R8
  wp_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wp && dataEv) |=> !ackHit);

  // R10
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    nvBusy |=> !ackHit);

  // R11
  sup_reset_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    supReset |=> (!ackHit && !rdValid));
endmodule

bind cfg_lock_seq cfg_lock_chk chk_i (
  .clk(clk), .rstN(rstN), .devEv(devEv), .addrEv(addrEv), .dataEv(dataEv),
  .wp(wp), .supReset(supReset), .ackHit(ackHit), .rdValid(rdValid),
  .rdData(rdData), .wdSel(wdSel), .nvBusy(nvBusy)
);

// File: tb/cfg_lock_seq_tb.sv
`timescale 1ns/1ps
module cfg_lock_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEv = 0, devEv = 0, addrEv = 0, dataEv = 0, stopEv = 0;
  logic wp = 0, supReset = 0;
  logic [7:0] devByte = 0, addrByte = 0, dataByte = 0;
  logic ackHit, rdValid, nvBusy;
  logic [7:0] rdData;
  logic [1:0] wdSel;
  int nRun = 0, nFail = 0;
  logic lastRv;
  logic [7:0] lastRd;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_lock_seq dut_i (
    .clk(clk), .rstN(rstN), .startEv(startEv), .devEv(devEv), .devByte(devByte),
    .addrEv(addrEv), .addrByte(addrByte), .dataEv(dataEv), .dataByte(dataByte),
    .stopEv(stopEv), .wp(wp), .supReset(supReset), .ackHit(ackHit),
    .rdValid(rdValid), .rdData(rdData), .wdSel(wdSel), .nvBusy(nvBusy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 start, 1 device, 2 address, 3 data, 4 stop
  task automatic ev(input int kind, input logic [7:0] b, output logic ak);
    @(negedge clk);
    case (kind)
      0: startEv = 1;
      1: begin devEv = 1; devByte = b; end
      2: begin addrEv = 1; addrByte = b; end
      3: begin dataEv = 1; dataByte = b; end
      default: stopEv = 1;
    endcase
    @(negedge clk);
    startEv = 0; devEv = 0; addrEv = 0; dataEv = 0; stopEv = 0;
    ak = ackHit;
    lastRv = rdValid;
    lastRd = rdData;
  endtask

  task automatic writeTxn(input logic [7:0] d, output logic ak);
    logic a;
    ev(0, 0, a); ev(1, 8'hB0, a); ev(2, 8'hFF, a); ev(3, d, ak); ev(4, 0, a);
  endtask

  task automatic readTxn(output logic [7:0] v, output logic ok);
    logic a;
    ev(0, 0, a); ev(1, 8'hB0, a); ev(2, 8'hFF, a); ev(0, 0, a);
    ev(1, 8'hB1, ok);
    ok = ok && lastRv;
    v = lastRd;
    ev(4, 0, a);
  endtask

  task automatic expectRead(input logic [7:0] e, input string tag);
    logic [7:0] v; logic ok;
    readTxn(v, ok);
    chk(ok && v == e, tag, v, e);
  endtask

  task automatic waitIdle();
    repeat (40) @(negedge clk);
  endtask

  task automatic testReset();
    chk(wdSel == 2'b11, "R1 wd reset", wdSel, 3);
    chk(nvBusy == 0 && ackHit == 0, "R1 busy/ack reset", nvBusy, 0);
    expectRead(8'h60, "R1 R3 reset image");
  endtask

  task automatic testAddressing();
    logic a; logic [7:0] v; logic ok;
    ev(0, 0, a); ev(1, 8'hA0, a);
    chk(!a, "R2 wrong device nack", a, 0);
    ev(2, 8'hFF, a);
    chk(!a, "R2 rest ignored", a, 0);
    ev(4, 0, a);
    ev(0, 0, a); ev(1, 8'hB0, a);
    chk(a, "R2 device ack", a, 1);
    ev(2, 8'h01, a);
    chk(!a, "R3 wrong address nack", a, 0);
    ev(4, 0, a);
    ev(0, 0, a); ev(1, 8'hB1, ok);
    v = lastRd;
    chk(!ok, "R3 read without address nack", ok, 0);
    ev(4, 0, a);
  endtask

  task automatic testLockedWrites();
    logic a;
    writeTxn(8'h06, a);
    chk(!a, "R4 WE clear refuses 06", a, 0);
    writeTxn(8'h40, a);
    chk(!a, "R4 WE clear refuses 40", a, 0);
    writeTxn(8'h03, a);
    chk(!a, "R4 reserved bit refused", a, 0);
    expectRead(8'h60, "R4 unchanged");
  endtask

  task automatic testUnlock();
    logic a;
    writeTxn(8'h02, a);
    chk(a, "R5 02 ack", a, 1);
    chk(nvBusy == 0, "R5 no busy", nvBusy, 0);
    expectRead(8'h62, "R5 WE set");
    writeTxn(8'h06, a);
    expectRead(8'h66, "R5 RWE set");
    expectRead(8'h66, "R12 read keeps latches");
  endtask

  task automatic testEscape();
    logic a;
    writeTxn(8'h26, a);
    chk(a && wdSel == 2'b11, "R7 escape wd kept", wdSel, 3);
    expectRead(8'h66, "R7 RWE kept");
  endtask

  task automatic testCommit();
    logic a;
    writeTxn(8'h22, a);
    chk(nvBusy == 1, "R6 busy after commit", nvBusy, 1);
    chk(wdSel == 2'b01, "R6 wd stored", wdSel, 1);
    ev(0, 0, a); ev(1, 8'hB0, a);
    chk(!a, "R10 busy ignores bus", a, 0);
    ev(4, 0, a);
    waitIdle();
    chk(nvBusy == 0, "R6 busy ends", nvBusy, 0);
    expectRead(8'h22, "R6 RWE cleared");
  endtask

  task automatic testProtect();
    logic a;
    writeTxn(8'h06, a);
    wp = 1;
    writeTxn(8'h02, a);
    chk(!a, "R8 protected nack", a, 0);
    wp = 0;
    expectRead(8'h22, "R8 RWE cleared, wd kept");
  endtask

  task automatic testAbort();
    logic a;
    ev(0, 0, a); ev(1, 8'hB0, a); ev(2, 8'hFF, a); ev(3, 8'h06, a);
    chk(a, "R9 first byte ack", a, 1);
    ev(3, 8'h06, a);
    chk(!a, "R9 second byte nack", a, 0);
    ev(4, 0, a);
    expectRead(8'h22, "R9 write cancelled");
    ev(0, 0, a); ev(1, 8'hB0, a); ev(2, 8'hFF, a); ev(4, 0, a);
    expectRead(8'h22, "R9 early stop no change");
  endtask

  task automatic testSupReset();
    logic a;
    writeTxn(8'h06, a);
    ev(0, 0, a); ev(1, 8'hB0, a); ev(2, 8'hFF, a); ev(3, 8'h42, a);
    @(negedge clk); supReset = 1;
    @(negedge clk); supReset = 0;
    ev(4, 0, a);
    chk(wdSel == 2'b01 && nvBusy == 0, "R11 pending dropped", wdSel, 1);
    expectRead(8'h20, "R11 latches cleared");
  endtask

  task automatic testClearOrder();
    logic a;
    writeTxn(8'h02, a); writeTxn(8'h06, a); writeTxn(8'h02, a);
    chk(wdSel == 2'b00, "R6 02-06-02 clears wd", wdSel, 0);
    waitIdle();
    expectRead(8'h02, "R6 final image");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testAddressing();
    testLockedWrites();
    testUnlock();
    testEscape();
    testCommit();
    testProtect();
    testAbort();
    testSupReset();
    testClearOrder();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule